// File: doc/BRIEF.md
# Three-wire serial clock-chip master

This block runs the host side of a three-wire link to a small register slave such as a battery-backed timekeeper. The link has an enable line, a serial clock and one bidirectional data line. A host requests a transfer by pulsing a start strobe with a command byte and a byte count. The block raises enable, waits a setup delay and sends the command byte least significant bit first. It then either drives the write bytes it takes from a FIFO-style input port or releases the line and collects read bytes from the slave. The transfer ends with a hold delay, after which enable drops.

The serial clock comes from the system clock through a divider and idles low. Data changes after falling edges. Both the slave and the master capture on rising edges. A write transaction leaves the clock high when enable drops, which a fixed-polarity SPI master cannot do. A read transaction ends with the clock low. A full clock burst is a command byte followed by eight data bytes, and a RAM burst may carry up to 24 bytes. After enable drops, the block stays busy for one further serial period before it takes a new start.

Top module: `serial3_master`

## Requirements
- R1: After reset and whenever the block is idle, `ser_en`, `ser_clk`, `sd_oe`, `busy`, `done`, `rd_valid` and `wr_pop` are all low.
- R2: The command byte goes out first, bit 0 first. Each bit is valid on `sd_out` with `sd_oe` high at the rising edge of `ser_clk` that carries it.
- R3: A command whose bit 0 is 1 is a read. After the command, the master captures `sd_in` on each rising edge, bit 0 first. It presents each completed byte on `rd_data` with a one-cycle `rd_valid`, in the cycle in which the eighth rising edge of that byte appears.
- R4: A command whose bit 0 is 0 is a write. Each data byte is taken from `wr_data` and acknowledged by a one-cycle `wr_pop`, then sent bit 0 first, in order.
- R5: The transfer carries `nbytes` data bytes after the command. A count of 0 is treated as 1 and a count above MAX_BYTES (24) is treated as MAX_BYTES. There are exactly 8*(count+1) rising clock edges.
- R6: `ser_en` rises while `ser_clk` is low. The first rising clock edge follows (2*SETUP_PER+1)*DIV_HALF system cycles later.
- R7: In a write, the last rising edge leaves `ser_clk` high until and through the fall of `ser_en`, 2*HOLD_PER*DIV_HALF cycles later. In a read, `ser_clk` falls DIV_HALF cycles after the last rising edge and `ser_en` falls 2*HOLD_PER*DIV_HALF cycles after it.
- R8: While enable is high, after the first rising edge, `ser_clk` toggles exactly every DIV_HALF system cycles.
- R9: `done` pulses for one cycle, in the cycle in which `ser_en` falls. `busy` stays high until 2*DIV_HALF cycles after that fall. A start while busy is ignored.
- R10: `sd_oe` is high for the whole of a write, from the rise of enable to its fall. In a read it is high only for the command byte and drops at the falling edge that follows the last command bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| cmd | input | 8 | Command byte, bit 0 = 1 selects read |
| nbytes | input | CNT_W | Data byte count, clamped to 1..MAX_BYTES |
| wr_data | input | 8 | Head byte of the host write queue |
| wr_pop | output | 1 | Pulse: head write byte consumed |
| rd_data | output | 8 | Last completed read byte |
| rd_valid | output | 1 | Pulse: rd_data holds a new byte |
| done | output | 1 | Pulse when enable is released |
| busy | output | 1 | Transfer or closing gap in progress |
| ser_en | output | 1 | Link enable to the slave |
| ser_clk | output | 1 | Divided serial clock |
| sd_out | output | 1 | Outgoing data bit |
| sd_oe | output | 1 | Drive enable for the shared data line |
| sd_in | input | 1 | Incoming data bit from the line |

## Verification
A wrong state in the bit or byte position shows at once in the rising-edge bit stream. It appears as a misplaced command bit, a wrong count of rising edges, or `sd_oe` held or released on the wrong byte, all within the transfer in which it happens. A wrong divider or delay count changes the measured cycle spacing between enable and clock edges within one serial period. A wrong ending state shows in the clock level seen at the fall of enable, or in the time at which `busy` returns low. A misrouted capture shows as a wrong `rd_data` on the byte's `rd_valid` pulse.

// File: rtl/serial3_pkg.sv
package serial3_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_SHIFT = 3'd2,
    ST_HOLD  = 3'd3,
    ST_GAP   = 3'd4
  } st_t;

  // Requested byte count folded into the legal range 1..max_n.
  function automatic int clamp_count(input int n, input int max_n);
    if (n < 1) return 1;
    if (n > max_n) return max_n;
    return n;
  endfunction

  // Number of ticks loaded into the delay counter for a span of per serial periods.
  function automatic int span_load(input int per);
    return 2 * per - 1;
  endfunction

endpackage

// File: rtl/serial3_tick.sv
module serial3_tick #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/serial3_bitpos.sv
module serial3_bitpos #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [2:0]       bit_idx,
  output logic [CNT_W-1:0] byte_idx,
  output logic             last_bit
);
  assign last_bit = (bit_idx == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx  <= '0;
      byte_idx <= '0;
    end else if (clr) begin
      bit_idx  <= '0;
      byte_idx <= '0;
    end else if (adv) begin
      bit_idx <= bit_idx + 1'b1;
      if (last_bit) byte_idx <= byte_idx + 1'b1;
    end
  end
endmodule

// File: rtl/serial3_shifter.sv
module serial3_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] ld_val,
  input  logic       capture,
  input  logic       cap_bit,
  input  logic       shift_out,
  output logic [7:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (load)      q <= ld_val;
    else if (capture)   q <= {cap_bit, q[7:1]};
    else if (shift_out) q <= {1'b0, q[7:1]};
  end
endmodule

// File: rtl/serial3_master.sv
module serial3_master #(
  parameter int DIV_HALF  = 4,
  parameter int SETUP_PER = 1,
  parameter int HOLD_PER  = 1,
  parameter int MAX_BYTES = 24,
  parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       cmd,
  input  logic [CNT_W-1:0] nbytes,
  input  logic [7:0]       wr_data,
  output logic             wr_pop,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             busy,
  output logic             ser_en,
  output logic             ser_clk,
  output logic             sd_out,
  output logic             sd_oe,
  input  logic             sd_in
);
  import serial3_pkg::*;

  localparam int DLY_MAX    = 2 * ((SETUP_PER > HOLD_PER) ? SETUP_PER : HOLD_PER);
  localparam int DLY_W      = $clog2(DLY_MAX + 1);
  localparam logic [DLY_W-1:0] SETUP_LOAD = DLY_W'(span_load(SETUP_PER));
  localparam logic [DLY_W-1:0] HOLD_LOAD  = DLY_W'(span_load(HOLD_PER));

  st_t              st;
  logic [DLY_W-1:0] dly;
  logic [CNT_W-1:0] n_eff;
  logic             txn_rd;

  // Named internal events
  logic             tick;
  logic             accept;
  logic             bit_rise;
  logic             bit_fall;
  logic             rd_phase;
  logic             last_all;
  logic [2:0]       bit_idx;
  logic [CNT_W-1:0] byte_idx;
  logic             last_bit;
  logic [7:0]       sh_q;
  logic             ld_wr;

  assign accept   = (st == ST_IDLE) && start;
  assign bit_rise = (st == ST_SHIFT) && tick && !ser_clk;
  assign bit_fall = (st == ST_SHIFT) && tick && ser_clk;
  assign rd_phase = txn_rd && (byte_idx != '0);
  assign last_all = last_bit && (byte_idx == n_eff);
  assign ld_wr    = bit_fall && last_bit && !txn_rd;

  serial3_tick #(.DIV_HALF(DIV_HALF)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st != ST_IDLE),
    .tick (tick)
  );

  serial3_bitpos #(.CNT_W(CNT_W)) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (st == ST_IDLE),
    .adv     (bit_fall),
    .bit_idx (bit_idx),
    .byte_idx(byte_idx),
    .last_bit(last_bit)
  );

  serial3_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept || ld_wr),
    .ld_val   (accept ? cmd : wr_data),
    .capture  (bit_rise && rd_phase),
    .cap_bit  (sd_in),
    .shift_out(bit_fall && !last_bit && !rd_phase),
    .q        (sh_q)
  );

  assign busy   = (st != ST_IDLE);
  assign sd_oe  = ((st == ST_SETUP) || (st == ST_SHIFT) || (st == ST_HOLD)) && !rd_phase;
  assign sd_out = sd_oe & sh_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      dly      <= '0;
      n_eff    <= '0;
      txn_rd   <= 1'b0;
      ser_en   <= 1'b0;
      ser_clk  <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
      wr_pop   <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      wr_pop   <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st      <= ST_SETUP;
          ser_en  <= 1'b1;
          ser_clk <= 1'b0;
          txn_rd  <= cmd[0];
          n_eff   <= CNT_W'(clamp_count(int'(nbytes), MAX_BYTES));
          dly     <= SETUP_LOAD;
        end
        ST_SETUP: if (tick) begin
          if (dly == '0) st <= ST_SHIFT;
          else           dly <= dly - 1'b1;
        end
        ST_SHIFT: if (tick) begin
          if (!ser_clk) begin
            ser_clk <= 1'b1;
            if (rd_phase && last_bit) begin
              rd_valid <= 1'b1;
              rd_data  <= {sd_in, sh_q[7:1]};
            end
            if (last_all) begin
              st  <= ST_HOLD;
              dly <= HOLD_LOAD;
            end
          end else begin
            ser_clk <= 1'b0;
            if (ld_wr) wr_pop <= 1'b1;
          end
        end
        ST_HOLD: if (tick) begin
          if (txn_rd) ser_clk <= 1'b0;
          if (dly == '0) begin
            ser_en <= 1'b0;
            done   <= 1'b1;
            st     <= ST_GAP;
            dly    <= DLY_W'(1);
          end else begin
            dly <= dly - 1'b1;
          end
        end
        ST_GAP: if (tick) begin
          ser_clk <= 1'b0;
          if (dly == '0) st <= ST_IDLE;
          else           dly <= dly - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial3_checks.sv
module serial3_checks (
  input logic clk,
  input logic rst_n,
  input logic ser_en,
  input logic ser_clk,
  input logic sd_oe,
  input logic rd_valid,
  input logic wr_pop,
  input logic done,
  input logic busy,
  input logic tick,
  input logic txn_rd
);
  // R1
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_en && !ser_clk && !sd_oe && !done && !rd_valid && !wr_pop));

  // R6
  a_r6_en_rise_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_en) |-> !ser_clk);

  // R7
  a_r7_write_ends_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ser_en) && !txn_rd) |-> ser_clk);

  a_r7_read_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ser_en) && txn_rd) |-> !ser_clk);

  // R8
  a_r8_clk_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_clk) |-> $past(tick));

  // R10
  a_r10_drive_inside_enable: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> ser_en);

  // R3
  a_r3_capture_while_released: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!sd_oe && ser_en && txn_rd));

  // R4
  a_r4_pop_only_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pop |-> (!txn_rd && ser_en));

  // R9
  a_r9_done_with_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(ser_en));

  a_r9_gap_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_en) |=> (busy && !ser_en));
endmodule

bind serial3_master serial3_checks u_checks (
  .clk     (clk),
  .rst_n   (rst_n),
  .ser_en  (ser_en),
  .ser_clk (ser_clk),
  .sd_oe   (sd_oe),
  .rd_valid(rd_valid),
  .wr_pop  (wr_pop),
  .done    (done),
  .busy    (busy),
  .tick    (tick),
  .txn_rd  (txn_rd)
);

// File: tb/serial3_master_bench.sv
module serial3_master_bench;
  localparam int D    = 2;
  localparam int S    = 1;
  localparam int H    = 2;
  localparam int MAXB = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] cmd_i = '0;
  logic [4:0] nbytes_i = '0;
  logic [7:0] wr_data;
  logic       wr_pop;
  logic [7:0] rd_data;
  logic       rd_valid, done, busy, ser_en, ser_clk, sd_out, sd_oe;
  logic       sd_in = 1'b0;

  always #5 clk = ~clk;

  serial3_master #(.DIV_HALF(D), .SETUP_PER(S), .HOLD_PER(H), .MAX_BYTES(MAXB)) u_serial3_master (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd_i), .nbytes(nbytes_i),
    .wr_data(wr_data), .wr_pop(wr_pop), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .busy(busy), .ser_en(ser_en), .ser_clk(ser_clk),
    .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in)
  );

  int errs = 0;
  int checks = 0;

  // Host write queue and slave read image
  logic [7:0] wq [0:31];
  logic [7:0] sbytes [0:31];
  int npop;
  assign wr_data = wq[npop[4:0]];

  // Monitor state
  int  cyc = 0;
  logic p_en = 0, p_clk = 0, p_busy = 0;
  int  nrise, nrv, ndone, bad_period, last_tog;
  int  t_en_rise, t_first_rise, t_last_rise, t_en_fall, t_busy_fall, t_done;
  logic en_rise_clk, clk_at_fall, slave_read;
  logic tb_bits [0:255];
  logic tb_oe   [0:255];
  logic [7:0] rbuf [0:31];
  int  sidx;

  always @(negedge clk) begin
    cyc++;
    if (ser_en && !p_en) begin t_en_rise = cyc; en_rise_clk = ser_clk; end
    if (!ser_en && p_en) begin t_en_fall = cyc; clk_at_fall = ser_clk; end
    if (!busy && p_busy) t_busy_fall = cyc;
    if (ser_clk != p_clk && ser_en) begin
      if (nrise > 0 && (cyc - last_tog) != D) bad_period++;
      last_tog = cyc;
    end
    if (ser_clk && !p_clk && ser_en) begin
      if (nrise == 0) t_first_rise = cyc;
      if (nrise < 256) begin tb_bits[nrise] = sd_out; tb_oe[nrise] = sd_oe; end
      t_last_rise = cyc;
      nrise++;
    end
    if (!ser_clk && p_clk && ser_en && slave_read && nrise >= 8) begin
      sidx = nrise - 8;
      if (sidx < 256) sd_in = sbytes[sidx / 8][sidx % 8];
    end
    if (wr_pop) npop++;
    if (rd_valid) begin
      if (nrv < 32) rbuf[nrv] = rd_data;
      nrv++;
    end
    if (done) begin ndone++; t_done = cyc; end
    p_en = ser_en; p_clk = ser_clk; p_busy = busy;
  end

  task automatic check_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon(input logic rd);
    nrise = 0; nrv = 0; ndone = 0; npop = 0; bad_period = 0; last_tog = 0;
    t_en_rise = 0; t_first_rise = 0; t_last_rise = 0; t_en_fall = 0;
    t_busy_fall = 0; t_done = -1; en_rise_clk = 1'b1; clk_at_fall = 1'bx;
    slave_read = rd; sd_in = 1'b0;
  endtask

  // One transfer; inject > 0 pulses a second start that many cycles in.
  task automatic do_txn(input string tag, input logic [7:0] c, input int n_req, input int inject);
    int ne;
    int bad_cmd, bad_dat, bad_rd;
    logic rd;
    rd = c[0];
    ne = (n_req < 1) ? 1 : ((n_req > MAXB) ? MAXB : n_req);
    @(posedge clk); #1;
    clear_mon(rd);
    cmd_i = c; nbytes_i = 5'(n_req); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (inject > 0) begin
      repeat (inject) @(posedge clk);
      #1;
      cmd_i = ~c; nbytes_i = 5'd5; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (ndone == 0 || busy) @(posedge clk);
    #1;

    bad_cmd = 0; bad_dat = 0; bad_rd = 0;
    for (int k = 0; k < 8; k++)
      if (tb_bits[k] !== c[k] || tb_oe[k] !== 1'b1) bad_cmd++;
    for (int j = 0; j < ne; j++)
      for (int b = 0; b < 8; b++) begin
        if (rd) begin
          if (tb_oe[8 + 8*j + b] !== 1'b0) bad_dat++;
        end else if (tb_bits[8 + 8*j + b] !== wq[j][b] || tb_oe[8 + 8*j + b] !== 1'b1) begin
          bad_dat++;
        end
      end
    for (int j = 0; j < ne && j < nrv; j++)
      if (rbuf[j] !== sbytes[j]) bad_rd++;

    $display("scenario %s: cmd=%02h bytes=%0d", tag, c, ne);
    check_int("R2", {tag, " command bit errors"}, bad_cmd, 0);
    check_int("R5", {tag, " rising edges"}, nrise, 8 * (ne + 1));
    if (rd) begin
      check_int("R10", {tag, " read bits with line driven"}, bad_dat, 0);
      check_int("R3", {tag, " read bytes delivered"}, nrv, ne);
      check_int("R3", {tag, " read byte mismatches"}, bad_rd, 0);
      check_int("R4", {tag, " pops during read"}, npop, 0);
    end else begin
      check_int("R4", {tag, " write bit errors"}, bad_dat, 0);
      check_int("R4", {tag, " bytes popped"}, npop, ne);
      check_int("R3", {tag, " read strobes during write"}, nrv, 0);
    end
    check_int("R6", {tag, " clock level at enable rise"}, int'(en_rise_clk), 0);
    check_int("R6", {tag, " enable to first rise"}, t_first_rise - t_en_rise, (2*S + 1) * D);
    check_int("R7", {tag, " last rise to enable fall"}, t_en_fall - t_last_rise, 2 * H * D);
    check_int("R7", {tag, " clock level at enable fall"}, int'(clk_at_fall), rd ? 0 : 1);
    check_int("R8", {tag, " off-period clock toggles"}, bad_period, 0);
    check_int("R9", {tag, " done pulses"}, ndone, 1);
    check_int("R9", {tag, " done aligned with enable fall"}, t_done, t_en_fall);
    check_int("R9", {tag, " busy tail after enable fall"}, t_busy_fall - t_en_fall, 2 * D);
  endtask

  task automatic test_reset;
    check_int("R1", "ser_en after reset", int'(ser_en), 0);
    check_int("R1", "ser_clk after reset", int'(ser_clk), 0);
    check_int("R1", "sd_oe after reset", int'(sd_oe), 0);
    check_int("R1", "busy after reset", int'(busy), 0);
    check_int("R1", "done/rd_valid/wr_pop after reset", int'(done | rd_valid | wr_pop), 0);
  endtask

  task automatic test_idle_after(input string tag);
    repeat (3) @(posedge clk);
    #1;
    check_int("R1", {tag, " idle outputs"}, int'(ser_en | ser_clk | sd_oe | busy), 0);
  endtask

  bit finished = 0;

  initial begin
    for (int i = 0; i < 32; i++) begin
      wq[i]     = 8'(i * 37 + 11);
      sbytes[i] = 8'(i * 53 + 108) ^ 8'h5A;
    end
    npop = 0;
    clear_mon(1'b0);
    repeat (3) @(posedge clk);
    #1;
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    test_reset();

    do_txn("single write", 8'h8E, 1, 0);
    do_txn("clock burst write", 8'hBE, 8, 0);
    do_txn("clock burst read", 8'hBF, 8, 0);
    do_txn("single read", 8'h81, 1, 0);
    do_txn("zero count write", 8'hC0, 0, 0);
    do_txn("oversize read", 8'hFF, 31, 0);
    do_txn("start while busy", 8'h42, 2, 20);
    test_idle_after("after ignored start");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule